// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block sits beside the transmit and receive FIFOs of a serial controller and turns their fill levels into interrupt lines. Software picks, per direction, which fill condition raises the line through a 2-bit mode code. The FIFO storage is a fixed 16 bytes, so the number of elements it holds depends on the current word size. Every threshold scales with that element count.

The block also watches for three faults, each kept in a sticky flag. A push into a full receive FIFO is a receive overflow. A transmit pop taken while the transmit FIFO is empty is a transmit underrun. A second frame-sync pulse that arrives before the current frame has ended is a frame error. A fault interrupt is the level-sensitive OR of the flags whose enable bits are set.

The levels and flags are reported in one 32-bit status word. Field positions are fixed there because a register decoder outside the block reads them. There is no data stream through the block. All pins are plain control and status, sampled on each clock, so no valid/ready back-pressure applies. Every output follows its inputs after exactly one clock edge.

Top module: `fifo_irq_gen`

## Requirements
- R1: Receive mode `rx_mode` fires `irq_rx` on these conditions. Code 0: the receive level is 0. Code 1: the level is 1 or more. Code 2: the level is at least half the element depth. Code 3: the level is at least the element depth.
- R2: Transmit mode `tx_mode` fires `irq_tx` on these conditions. Code 0: the level is 0 and `tx_shift_busy` is low. Code 1: the level is 0. Code 2: the level is at most half the depth, meaning at least half the slots are free. Code 3: the level is below the depth.
- R3: The element depth is 16, 8 or 4 for `word_size` codes 0 (8-bit), 1 (16-bit) and 2 (32-bit). The reserved code 3 behaves as code 2.
- R4: `status[20:16]` reports the transmit level and `status[28:24]` reports the receive level. Both are the values sampled at the previous clock edge.
- R5: `status[5]` is 1 exactly when the reported receive level is 0.
- R6: An `rx_push` while `rx_level` is at or above the current depth sets the overflow flag `status[6]`. A push below full leaves the flag unchanged.
- R7: A `tx_pop` while `tx_level` is 0 sets the underrun flag `status[8]`. A pop from a non-empty FIFO leaves the flag unchanged.
- R8: A `frame_sync` pulse while a frame is open sets the frame-error flag `status[12]`. A frame opens on `frame_sync` and closes on `frame_end`. If `frame_end` and `frame_sync` come in the same cycle, the frame closes and a new one opens with no error.
- R9: Each flag stays set until its `err_clr` bit is pulsed. The `err_clr` bits are bit 0 for underrun, bit 1 for overflow and bit 2 for frame error. A set event in the same cycle as a clear leaves the flag set.
- R10: `irq_fault` is high while any flag is set and its `err_en` bit is high. The `err_en` bits are bit 0 for underrun, bit 1 for overflow and bit 2 for frame error.
- R11: While `ctrl_on` was low at the previous edge, all three interrupt lines are low. Fault flags still latch during that time.
- R12: After reset all interrupt lines are low and `status` equals 32'h0000_0020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_on | input | 1 | Master enable for the interrupt lines |
| rx_mode | input | 2 | Receive interrupt condition code |
| tx_mode | input | 2 | Transmit interrupt condition code |
| word_size | input | 2 | Word size code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| tx_level | input | 5 | Transmit FIFO element count |
| rx_level | input | 5 | Receive FIFO element count |
| tx_shift_busy | input | 1 | Transmit shifter still holds a word |
| rx_push | input | 1 | Receive FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe (shifter load) |
| frame_sync | input | 1 | Frame-sync pulse |
| frame_end | input | 1 | Frame-close pulse |
| err_en | input | 3 | Fault enables: underrun, overflow, frame error |
| err_clr | input | 3 | Flag clear strobes: underrun, overflow, frame error |
| irq_tx | output | 1 | Transmit threshold interrupt |
| irq_rx | output | 1 | Receive threshold interrupt |
| irq_fault | output | 1 | Fault interrupt |
| status | output | 32 | Status word |

## Verification
The bench builds the block with the default 16-byte FIFO. That gives a 5-bit level field and depths of 16, 8 and 4 elements, so one build covers all three word sizes and the reserved size code. The depths are small, so the exact boundary on both sides of each threshold can be reached: half minus one and half, depth minus one and depth. Both edges of the overflow condition at the 4-element depth are also in reach.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [1:0] {
    WS_BYTE = 2'd0,
    WS_HALF = 2'd1,
    WS_WORD = 2'd2,
    WS_RSVD = 2'd3
  } wsize_e;

  typedef enum logic [1:0] {
    RXM_EMPTY = 2'd0,
    RXM_ANY   = 2'd1,
    RXM_HALF  = 2'd2,
    RXM_FULL  = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    TXM_IDLE  = 2'd0,
    TXM_EMPTY = 2'd1,
    TXM_HALF  = 2'd2,
    TXM_SLOT  = 2'd3
  } tx_mode_e;

  // fault flag indices, shared by enables, clears and status
  localparam int ERR_UR = 0;
  localparam int ERR_OV = 1;
  localparam int ERR_FE = 2;
  localparam int N_ERR  = 3;

  // status word bit positions read by the register decoder
  localparam int ST_RX_EMPTY = 5;
  localparam int ST_OV       = 6;
  localparam int ST_UR       = 8;
  localparam int ST_FE       = 12;
  localparam int ST_TXL      = 16;
  localparam int ST_RXL      = 24;

  function automatic int unsigned size_shift(input logic [1:0] ws);
    case (wsize_e'(ws))
      WS_BYTE: return 0;
      WS_HALF: return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/fti_depth.sv
module fti_depth #(
  parameter int FIFO_BYTES = 16,
  parameter int LVL_W      = 5
) (
  input  logic [1:0]       word_size,
  output logic [LVL_W-1:0] depth,
  output logic [LVL_W-1:0] half
);
  import fti_pkg::*;

  always_comb begin
    depth = LVL_W'(FIFO_BYTES >> size_shift(word_size));
    half  = depth >> 1;
  end

endmodule

// File: rtl/fti_rx_cmp.sv
module fti_rx_cmp #(
  parameter int LVL_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] depth,
  input  logic [LVL_W-1:0] half,
  output logic             hit
);
  import fti_pkg::*;

  always_comb begin
    case (rx_mode_e'(mode))
      RXM_EMPTY: hit = (level == '0);
      RXM_ANY:   hit = (level != '0);
      RXM_HALF:  hit = (level >= half);
      default:   hit = (level >= depth);
    endcase
  end

endmodule

// File: rtl/fti_tx_cmp.sv
module fti_tx_cmp #(
  parameter int LVL_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] depth,
  input  logic [LVL_W-1:0] half,
  input  logic             busy,
  output logic             hit
);
  import fti_pkg::*;

  // free slots are depth - level; free >= depth/2 <=> level <= depth/2
  always_comb begin
    case (tx_mode_e'(mode))
      TXM_IDLE:  hit = (level == '0) && !busy;
      TXM_EMPTY: hit = (level == '0);
      TXM_HALF:  hit = (level <= half);
      default:   hit = (level < depth);
    endcase
  end

endmodule

// File: rtl/fti_evt_det.sv
module fti_evt_det #(
  parameter int LVL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_push,
  input  logic                    tx_pop,
  input  logic [LVL_W-1:0]        rx_level,
  input  logic [LVL_W-1:0]        tx_level,
  input  logic [LVL_W-1:0]        depth_now,
  input  logic                    frame_sync,
  input  logic                    frame_end,
  output logic [fti_pkg::N_ERR-1:0] set_evt
);
  import fti_pkg::*;

  logic in_frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          in_frame_q <= 1'b0;
    else if (frame_sync) in_frame_q <= 1'b1;
    else if (frame_end)  in_frame_q <= 1'b0;
  end

  always_comb begin
    set_evt         = '0;
    set_evt[ERR_OV] = rx_push && (rx_level >= depth_now);
    set_evt[ERR_UR] = tx_pop && (tx_level == '0);
    set_evt[ERR_FE] = frame_sync && in_frame_q && !frame_end;
  end

  // R8: a sync pulse always leaves a frame open
  assert_frame_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> in_frame_q);

endmodule

// File: rtl/fti_err_latch.sv
module fti_err_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr[i])     flags[i] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt[i] && clr[i]) |=> !flags[i]);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt[i] && !clr[i]) |=> $stable(flags[i]));
  end

endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen #(
  parameter int FIFO_BYTES = 16,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_on,
  input  logic [1:0]       rx_mode,
  input  logic [1:0]       tx_mode,
  input  logic [1:0]       word_size,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_shift_busy,
  input  logic             rx_push,
  input  logic             tx_pop,
  input  logic             frame_sync,
  input  logic             frame_end,
  input  logic [2:0]       err_en,
  input  logic [2:0]       err_clr,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_fault,
  output logic [31:0]      status
);
  import fti_pkg::*;

  // sampled configuration and levels
  logic             on_q;
  logic [1:0]       rxm_q, txm_q, ws_q;
  logic [LVL_W-1:0] txl_q, rxl_q;
  logic             busy_q;
  logic [N_ERR-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      rxm_q  <= '0;
      txm_q  <= '0;
      ws_q   <= '0;
      txl_q  <= '0;
      rxl_q  <= '0;
      busy_q <= 1'b0;
      en_q   <= '0;
    end else begin
      on_q   <= ctrl_on;
      rxm_q  <= rx_mode;
      txm_q  <= tx_mode;
      ws_q   <= word_size;
      txl_q  <= tx_level;
      rxl_q  <= rx_level;
      busy_q <= tx_shift_busy;
      en_q   <= err_en;
    end
  end

  // depth for live event detection and for sampled thresholds
  logic [LVL_W-1:0] depth_now, half_now, depth_q, half_q;

  fti_depth #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_depth_now (
    .word_size (word_size),
    .depth     (depth_now),
    .half      (half_now)
  );

  fti_depth #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_depth_q (
    .word_size (ws_q),
    .depth     (depth_q),
    .half      (half_q)
  );

  logic rx_hit, tx_hit;

  fti_rx_cmp #(.LVL_W(LVL_W)) u_rx_cmp (
    .mode  (rxm_q),
    .level (rxl_q),
    .depth (depth_q),
    .half  (half_q),
    .hit   (rx_hit)
  );

  fti_tx_cmp #(.LVL_W(LVL_W)) u_tx_cmp (
    .mode  (txm_q),
    .level (txl_q),
    .depth (depth_q),
    .half  (half_q),
    .busy  (busy_q),
    .hit   (tx_hit)
  );

  logic [N_ERR-1:0] set_evt, flags;

  fti_evt_det #(.LVL_W(LVL_W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_push    (rx_push),
    .tx_pop     (tx_pop),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .depth_now  (depth_now),
    .frame_sync (frame_sync),
    .frame_end  (frame_end),
    .set_evt    (set_evt)
  );

  fti_err_latch #(.N(N_ERR)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr     (err_clr),
    .flags   (flags)
  );

  logic unused_half_now;
  assign unused_half_now = ^half_now;

  always_comb begin
    irq_rx    = on_q && rx_hit;
    irq_tx    = on_q && tx_hit;
    irq_fault = on_q && |(flags & en_q);

    status                     = '0;
    status[ST_RX_EMPTY]        = (rxl_q == '0);
    status[ST_OV]              = flags[ERR_OV];
    status[ST_UR]              = flags[ERR_UR];
    status[ST_FE]              = flags[ERR_FE];
    status[ST_TXL +: LVL_W]    = txl_q;
    status[ST_RXL +: LVL_W]    = rxl_q;
  end

  // R4: level fields track the inputs one edge later
  assert_level_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status[ST_RXL +: LVL_W] == $past(rx_level)) &&
                     (status[ST_TXL +: LVL_W] == $past(tx_level)));

  // R11: disabled block keeps every line low
  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl_on)) |-> (!irq_tx && !irq_rx && !irq_fault));

  // R6: push at full latches overflow
  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && (rx_level >= depth_now)) |=> status[ST_OV]);

  // R7: pop from empty latches underrun
  assert_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && (tx_level == '0)) |=> status[ST_UR]);

  // R10: enabled overflow flag drives the fault line
  assert_fault_ov_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_on) && $past(err_en[ERR_OV]) && status[ST_OV])
      |-> irq_fault);

endmodule

// File: tb/fifo_irq_gen_tb.sv
`timescale 1ns/1ps
module fifo_irq_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_on = 1'b0;
  logic [1:0]  rx_mode = '0, tx_mode = '0, word_size = '0;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic        tx_shift_busy = 1'b0, rx_push = 1'b0, tx_pop = 1'b0;
  logic        frame_sync = 1'b0, frame_end = 1'b0;
  logic [2:0]  err_en = '0, err_clr = '0;
  logic        irq_tx, irq_rx, irq_fault;
  logic [31:0] status;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fifo_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_on(ctrl_on),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .word_size(word_size),
    .tx_level(tx_level), .rx_level(rx_level), .tx_shift_busy(tx_shift_busy),
    .rx_push(rx_push), .tx_pop(tx_pop), .frame_sync(frame_sync),
    .frame_end(frame_end), .err_en(err_en), .err_clr(err_clr),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_fault(irq_fault), .status(status)
  );

  // size, rx_mode, tx_mode, tx_level, rx_level, busy, exp_tx, exp_rx
  localparam int NV = 16;
  localparam int V [NV][8] = '{
    '{0, 0, 0,  0,  0, 0, 1, 1},
    '{0, 0, 0,  0,  1, 1, 0, 0},
    '{0, 1, 1,  0,  1, 1, 1, 1},
    '{0, 1, 1,  1,  0, 0, 0, 0},
    '{0, 2, 2,  8,  8, 0, 1, 1},
    '{0, 2, 2,  9,  7, 0, 0, 0},
    '{1, 2, 2,  4,  4, 0, 1, 1},
    '{1, 2, 2,  5,  3, 0, 0, 0},
    '{2, 3, 3,  3,  4, 0, 1, 1},
    '{2, 3, 3,  4,  3, 0, 0, 0},
    '{0, 3, 3, 15, 16, 0, 1, 1},
    '{0, 3, 3, 16, 15, 0, 0, 0},
    '{1, 3, 3,  7,  8, 0, 1, 1},
    '{2, 2, 2,  2,  2, 0, 1, 1},
    '{2, 2, 2,  3,  1, 0, 0, 0},
    '{3, 3, 3,  3,  4, 0, 1, 1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12 status", status, 32'h0000_0020);
    chk("R12 irqs", {29'd0, irq_tx, irq_rx, irq_fault}, 32'd0);

    // R1 R2 R3 R4 R5: vector table
    ctrl_on = 1'b1;
    for (int i = 0; i < NV; i++) begin
      word_size     = V[i][0][1:0];
      rx_mode       = V[i][1][1:0];
      tx_mode       = V[i][2][1:0];
      tx_level      = V[i][3][4:0];
      rx_level      = V[i][4][4:0];
      tx_shift_busy = V[i][5][0];
      @(negedge clk);
      chk($sformatf("R2 R3 irq_tx vec%0d", i), {31'd0, irq_tx}, V[i][6]);
      chk($sformatf("R1 R3 irq_rx vec%0d", i), {31'd0, irq_rx}, V[i][7]);
      chk($sformatf("R4 txlvl vec%0d", i), {27'd0, status[20:16]}, V[i][3]);
      chk($sformatf("R4 rxlvl vec%0d", i), {27'd0, status[28:24]}, V[i][4]);
      chk($sformatf("R5 empty vec%0d", i), {31'd0, status[5]}, (V[i][4] == 0) ? 1 : 0);
    end

    // R11: disabled, conditions true, lines stay low
    ctrl_on = 1'b0; word_size = 2'd0; rx_mode = 2'd0; tx_mode = 2'd0;
    tx_level = 0; rx_level = 0; tx_shift_busy = 1'b0; err_en = 3'b111;
    @(negedge clk);
    chk("R11 lines off", {30'd0, irq_tx, irq_rx}, 32'd0);
    // R11 R6: flags still latch while off
    rx_level = 16; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
    chk("R11 ovf latched off", {31'd0, status[6]}, 32'd1);
    chk("R11 fault off", {31'd0, irq_fault}, 32'd0);
    ctrl_on = 1'b1;
    @(negedge clk);
    chk("R10 fault on", {31'd0, irq_fault}, 32'd1);
    err_clr = 3'b010;
    @(negedge clk);
    err_clr = 3'b000;
    chk("R9 ovf cleared", {31'd0, status[6]}, 32'd0);
    chk("R10 fault cleared", {31'd0, irq_fault}, 32'd0);

    // R6 R3: overflow boundary at 4-element depth
    word_size = 2'd2; rx_level = 3; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
    chk("R6 push below full", {31'd0, status[6]}, 32'd0);
    rx_level = 4; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
    chk("R6 push at full", {31'd0, status[6]}, 32'd1);
    err_clr = 3'b010;
    @(negedge clk);
    err_clr = 3'b000;

    // R9: set and clear together, then sticky
    rx_push = 1'b1; err_clr = 3'b010;
    @(negedge clk);
    rx_push = 1'b0; err_clr = 3'b000;
    chk("R9 set wins", {31'd0, status[6]}, 32'd1);
    @(negedge clk);
    chk("R9 sticky", {31'd0, status[6]}, 32'd1);
    err_clr = 3'b010;
    @(negedge clk);
    err_clr = 3'b000;

    // R7: underrun
    tx_level = 1; tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    chk("R7 pop nonempty", {31'd0, status[8]}, 32'd0);
    tx_level = 0; tx_pop = 1'b1; err_en = 3'b001;
    @(negedge clk);
    tx_pop = 1'b0;
    chk("R7 pop empty", {31'd0, status[8]}, 32'd1);
    chk("R10 underrun enabled", {31'd0, irq_fault}, 32'd1);
    err_en = 3'b110;
    @(negedge clk);
    chk("R10 underrun masked", {31'd0, irq_fault}, 32'd0);
    err_clr = 3'b001;
    @(negedge clk);
    err_clr = 3'b000;
    chk("R9 ur cleared", {31'd0, status[8]}, 32'd0);

    // R8: frame errors
    frame_sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    frame_sync = 1'b0;
    chk("R8 double sync", {31'd0, status[12]}, 32'd1);
    chk("R10 frame fault", {31'd0, irq_fault}, 32'd1);
    frame_end = 1'b1; err_clr = 3'b100;
    @(negedge clk);
    frame_end = 1'b0; err_clr = 3'b000;
    chk("R9 fe cleared", {31'd0, status[12]}, 32'd0);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0; frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    chk("R8 closed then reopened", {31'd0, status[12]}, 32'd0);
    frame_sync = 1'b1; frame_end = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0; frame_end = 1'b0;
    chk("R8 end with sync", {31'd0, status[12]}, 32'd0);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule